// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-clock SRAM with a 32-bit word split into four 8-bit byte lanes. Its depth is set by a parameter. Every request-side input is registered on the rising clock edge. This covers the address, write data, chip select, burst-start strobe, write strobe, byte-lane enables, global write strobe and burst-order select. An access therefore happens one edge after its inputs are captured.

A burst begins when the start strobe and chip select are captured low together. The captured address becomes the burst base. On every following cycle in which the chip stays selected and no new start arrives, the block advances a two-bit beat counter and ignores the address pins. The burst walks the four words of an aligned group, either in linear order or in interleaved order, and wraps after four beats.

Read data passes through the array read register and then an output register, so it reaches the data pins two clocks after the capturing edge. The output-enable and snooze inputs act without a clock. Either one stops the pins from driving. Snooze also freezes all array activity.

The burst controller has two named states. BST_IDLE means no burst is open. BST_RUN means a burst is open and its base and beat are held. The transitions are as follows:
- **start** (idle or run → run): a captured start loads the base address and sets the beat to 0.
- **step** (run → run): a captured select with no start advances the beat.
- **deselect** (run → idle): a captured deselect closes the burst.
- **hold** (idle → idle, or any state while snoozing): nothing changes.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset the bus is not driven: `dq_drv` is 0 and `dq_o` is all zeros.
- R2: A read captured at clock edge k drives its word on `dq_o`, with `dq_drv` high, after edge k+2.
- R3: With `burst_mode` = 0 at the start, beat j reads or writes the address whose low two bits are (base + j) mod 4. The upper bits stay equal to those of the base.
- R4: With `burst_mode` = 1 at the start, beat j uses low two bits equal to base[1:0] XOR j. The upper bits stay unchanged.
- R5: A burst continues past four beats by wrapping within its four-word group. Beat 4 revisits the base address.
- R6: With `wr_n` low and `gw_n` high, lane i (bits 8i+7..8i) is written only if `lane_en_n[i]` is low. The other lanes keep their contents.
- R7: With `gw_n` low, all four lanes are written, whatever the values of `lane_en_n` and `wr_n`.
- R8: With `wr_n` low, `gw_n` high and every `lane_en_n` bit high, the word is left unchanged.
- R9: A captured deselect (`ce_n` high) stops the access in the next cycle, and the bus stops driving one registered cycle later. Selecting again without a start strobe performs no access.
- R10: While `oe_n` is high, `dq_drv` is 0 and `dq_o` is zero, with no clock edge needed.
- R11: While `snooze` is high, no read or write is performed and the beat counter does not move. Stored words are kept, and the bus is not driven.
- R12: The address pins are ignored on continuation beats of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| addr | input | ADDR_W | Word address, used as the burst base when a burst starts |
| wdata | input | 32 | Write data, byte lane i in bits 8i+7..8i |
| ce_n | input | 1 | Active-low chip select |
| adsc_n | input | 1 | Active-low burst start strobe |
| wr_n | input | 1 | Active-low write strobe for the enabled lanes |
| lane_en_n | input | 4 | Active-low byte-lane enables |
| gw_n | input | 1 | Active-low global write of all lanes |
| burst_mode | input | 1 | 0 selects linear order, 1 selects interleaved order; sampled at burst start |
| oe_n | input | 1 | Active-low output enable, not clocked |
| snooze | input | 1 | Standby: blocks accesses and drivers, not clocked |
| dq_o | output | 32 | Read data, zero when not driven |
| dq_drv | output | 1 | High when the data bus is being driven |

## Verification
The bench sweeps every base position within a group in both burst orders. It writes a full group and reads six beats with junk on the address pins, so a design that loaded the pins on continuation beats, used the wrong order, or overran the group instead of wrapping returns a wrong word. It also reads groups in the opposite order from the one used to write them, to expose an order applied on only one side.

All sixteen byte-lane masks are tried over a known background. The bench also checks that global write overrides both a partial mask and a released write strobe, and that a write strobe with no lanes enabled changes nothing. A design that merged these controls wrongly would corrupt or miss bytes.

On the timing side, the bench samples the exact cycle that data appears and the exact cycle that drive drops after a deselect. It confirms that reselecting without a start yields no data, and that output enable and snooze cut the drivers between clock edges. A design with an extra or missing pipeline stage, a sticky burst, or clocked output control would be caught. Finally, a global write attempted while snoozing must leave the word intact.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic {
        BST_IDLE = 1'b0,
        BST_RUN  = 1'b1
    } bst_state_e;

    // Low address bits of a burst beat: XOR order or modular-add order.
    function automatic logic [BEAT_W-1:0] beat_offset(
        input logic [BEAT_W-1:0] base_lo,
        input logic [BEAT_W-1:0] beat,
        input logic              ilv
    );
        if (ilv) return base_lo ^ beat;
        return base_lo + beat;
    endfunction

endpackage

// File: rtl/sbs_in_reg.sv
module sbs_in_reg #(
    parameter  int ADDR_W = 6,
    parameter  int LANES  = 4,
    parameter  int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ce_n,
    input  logic              adsc_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_en_n,
    input  logic              gw_n,
    input  logic              burst_mode,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              sel_q,
    output logic              start_q,
    output logic              wr_q,
    output logic [LANES-1:0]  lanes_q,
    output logic              gw_q,
    output logic              ilv_q
);

    // Control capture: reset so that no phantom access follows reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            start_q <= 1'b0;
            wr_q    <= 1'b0;
            lanes_q <= '0;
            gw_q    <= 1'b0;
            ilv_q   <= 1'b0;
        end else begin
            sel_q   <= !ce_n;
            start_q <= !ce_n && !adsc_n;
            wr_q    <= !wr_n;
            lanes_q <= ~lane_en_n;
            gw_q    <= !gw_n;
            ilv_q   <= burst_mode;
        end
    end

    // Datapath capture: no reset needed.
    always_ff @(posedge clk) begin
        addr_q  <= addr;
        wdata_q <= wdata;
    end

endmodule

// File: rtl/sbs_burst_ctl.sv
module sbs_burst_ctl
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_q,
    input  logic              start_q,
    input  logic              wr_q,
    input  logic [LANES-1:0]  lanes_q,
    input  logic              gw_q,
    input  logic              ilv_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic              snooze,
    output logic              acc_en,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  lane_we,
    output logic              rd_en,
    output bst_state_e        state_q,
    output logic [BEAT_W-1:0] beat_q
);

    bst_state_e        state_n;
    logic [ADDR_W-1:0] base_q, base_n;
    logic [BEAT_W-1:0] beat_n;
    logic              ilv_b, ilv_n;
    logic              is_wr;

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BST_IDLE;
            base_q  <= '0;
            beat_q  <= '0;
            ilv_b   <= 1'b0;
        end else begin
            state_q <= state_n;
            base_q  <= base_n;
            beat_q  <= beat_n;
            ilv_b   <= ilv_n;
        end
    end

    // Transition process: start, step, deselect, hold.
    always_comb begin
        state_n = state_q;
        base_n  = base_q;
        beat_n  = beat_q;
        ilv_n   = ilv_b;
        acc_en  = 1'b0;
        if (!snooze) begin
            unique case (state_q)
                BST_IDLE: begin
                    if (start_q) begin
                        state_n = BST_RUN;
                        base_n  = addr_q;
                        beat_n  = '0;
                        ilv_n   = ilv_q;
                        acc_en  = 1'b1;
                    end
                end
                BST_RUN: begin
                    if (!sel_q) begin
                        state_n = BST_IDLE;
                    end else if (start_q) begin
                        base_n  = addr_q;
                        beat_n  = '0;
                        ilv_n   = ilv_q;
                        acc_en  = 1'b1;
                    end else begin
                        beat_n  = beat_q + 1'b1;
                        acc_en  = 1'b1;
                    end
                end
                default: state_n = BST_IDLE;
            endcase
        end
    end

    // Output process: access address and per-lane strobes.
    always_comb begin
        acc_addr = {base_n[ADDR_W-1:BEAT_W], beat_offset(base_n[BEAT_W-1:0], beat_n, ilv_n)};
        is_wr    = gw_q || wr_q;
        lane_we  = '0;
        if (acc_en && is_wr) lane_we = gw_q ? {LANES{1'b1}} : lanes_q;
        rd_en    = acc_en && !is_wr;
    end

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter  int ADDR_W = 6,
    parameter  int LANES  = 4,
    parameter  int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [LANES-1:0]  lane_we,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];
        logic [LANE_W-1:0] rd_byte;

        always_ff @(posedge clk) begin
            if (lane_we[g]) bank[acc_addr] <= wdata_q[g*LANE_W +: LANE_W];
            if (rd_en)      rd_byte        <= bank[acc_addr];
        end

        assign rd_data[g*LANE_W +: LANE_W] = rd_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_vld <= 1'b0;
        else        rd_vld <= rd_en;
    end

endmodule

// File: rtl/sbs_out_pipe.sv
module sbs_out_pipe #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_vld,
    input  logic              oe_n,
    input  logic              snooze,
    output logic              out_vld,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_drv
);

    logic [DATA_W-1:0] out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            out_vld <= 1'b0;
        end else begin
            out_q   <= rd_data;
            out_vld <= rd_vld;
        end
    end

    // Output enable and snooze gate the drivers without a clock.
    always_comb begin
        dq_drv = out_vld && !oe_n && !snooze;
        dq_o   = dq_drv ? out_q : '0;
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter  int ADDR_W = 6,
    parameter  int LANES  = 4,
    parameter  int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ce_n,
    input  logic              adsc_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_en_n,
    input  logic              gw_n,
    input  logic              burst_mode,
    input  logic              oe_n,
    input  logic              snooze,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_drv
);

    logic [ADDR_W-1:0] addr_q, acc_addr;
    logic [DATA_W-1:0] wdata_q, rd_data;
    logic              sel_q, start_q, wr_q, gw_q, ilv_q;
    logic [LANES-1:0]  lanes_q, lane_we;
    logic              acc_en, rd_en, rd_vld, out_vld;
    bst_state_e        state_q;
    logic [BEAT_W-1:0] beat_q;

    sbs_in_reg #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .ce_n(ce_n),
        .adsc_n(adsc_n), .wr_n(wr_n), .lane_en_n(lane_en_n), .gw_n(gw_n),
        .burst_mode(burst_mode), .addr_q(addr_q), .wdata_q(wdata_q),
        .sel_q(sel_q), .start_q(start_q), .wr_q(wr_q), .lanes_q(lanes_q),
        .gw_q(gw_q), .ilv_q(ilv_q)
    );

    sbs_burst_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
        .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .start_q(start_q),
        .wr_q(wr_q), .lanes_q(lanes_q), .gw_q(gw_q), .ilv_q(ilv_q),
        .addr_q(addr_q), .snooze(snooze), .acc_en(acc_en),
        .acc_addr(acc_addr), .lane_we(lane_we), .rd_en(rd_en),
        .state_q(state_q), .beat_q(beat_q)
    );

    sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .lane_we(lane_we),
        .rd_en(rd_en), .wdata_q(wdata_q), .rd_data(rd_data), .rd_vld(rd_vld)
    );

    sbs_out_pipe #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .rd_vld(rd_vld),
        .oe_n(oe_n), .snooze(snooze), .out_vld(out_vld), .dq_o(dq_o),
        .dq_drv(dq_drv)
    );

endmodule

// File: rtl/sbs_chk.sv
module sbs_chk
    import sbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_q,
    input logic              start_q,
    input logic              gw_q,
    input logic              acc_en,
    input logic              rd_en,
    input logic              snooze,
    input logic              oe_n,
    input logic              dq_drv,
    input logic              out_vld,
    input logic [LANES-1:0]  lane_we,
    input bst_state_e        state_q,
    input logic [BEAT_W-1:0] beat_q
);

    AST_DESEL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_q |-> !acc_en);                                                    // R9
    AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && gw_q) |-> (lane_we == {LANES{1'b1}}));                       // R7
    AST_SNOOZE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        snooze |-> ((lane_we == '0) && !rd_en));                                // R11
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> ##1 out_vld);                                                 // R2
    AST_BEAT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BST_RUN && sel_q && !start_q && !snooze)
            |=> (beat_q == BEAT_W'($past(beat_q) + 1'b1)));                     // R5
    AST_SNOOZE_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        snooze |=> $stable(beat_q));                                            // R11
    AST_OE_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_drv);                                                      // R10

endmodule

bind sync_burst_sram sbs_chk #(.LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .start_q(start_q), .gw_q(gw_q),
    .acc_en(acc_en), .rd_en(rd_en), .snooze(snooze), .oe_n(oe_n),
    .dq_drv(dq_drv), .out_vld(out_vld), .lane_we(lane_we),
    .state_q(state_q), .beat_q(beat_q)
);

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr;
    logic [31:0]   wdata;
    logic          ce_n, adsc_n, wr_n, gw_n, burst_mode, oe_n, snooze;
    logic [3:0]    lane_en_n;
    logic [31:0]   dq_o;
    logic          dq_drv;

    logic [31:0]   exp_mem [64];
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .ce_n(ce_n),
        .adsc_n(adsc_n), .wr_n(wr_n), .lane_en_n(lane_en_n), .gw_n(gw_n),
        .burst_mode(burst_mode), .oe_n(oe_n), .snooze(snooze),
        .dq_o(dq_o), .dq_drv(dq_drv)
    );

    function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] base, int k, bit ilv);
        logic [1:0] kk;
        logic [1:0] lo;
        kk = 2'(k);
        lo = ilv ? (base[1:0] ^ kk) : (base[1:0] + kk);
        return {base[AW-1:2], lo};
    endfunction

    task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_idle();
        ce_n = 1'b1; adsc_n = 1'b1; wr_n = 1'b1; gw_n = 1'b1;
        lane_en_n = 4'hF; addr = '0; wdata = '0;
    endtask

    task automatic write_burst(logic [AW-1:0] base, bit ilv, int n, logic [3:0] len_n,
                               bit gwn, bit wrn, logic [31:0] seed);
        for (int k = 0; k < n; k++) begin
            logic [AW-1:0] a;
            logic [31:0]   d;
            a = beat_addr(base, k, ilv);
            d = seed ^ (32'(k) * 32'h01030507);
            ce_n = 1'b0; adsc_n = (k != 0); addr = (k == 0) ? base : ~base;
            burst_mode = ilv; wdata = d; lane_en_n = len_n; gw_n = gwn; wr_n = wrn;
            tick();
            for (int l = 0; l < 4; l++)
                if (!gwn || (!wrn && !len_n[l])) exp_mem[a][l*8 +: 8] = d[l*8 +: 8];
        end
        set_idle();
        tick();
        tick();
    endtask

    // Beat j captured on tick j is checked after tick j+2 (R2); pins carry junk on
    // continuation beats (R12); one beat past the end must not drive (R9).
    task automatic read_burst(logic [AW-1:0] base, bit ilv, int n, string req);
        for (int t = 0; t < n + 3; t++) begin
            if (t == 0) begin
                ce_n = 1'b0; adsc_n = 1'b0; addr = base; burst_mode = ilv;
            end else if (t < n) begin
                ce_n = 1'b0; adsc_n = 1'b1; addr = base ^ AW'(t * 7 + 1);
            end else begin
                set_idle();
            end
            tick();
            if (t >= 2) begin
                int j;
                j = t - 2;
                if (j < n) begin
                    check_eq({req, " R2 drive"}, 32'(dq_drv), 32'd1);
                    check_eq(req, dq_o, exp_mem[beat_addr(base, j, ilv)]);
                end else begin
                    check_eq("R9 drive release after burst", 32'(dq_drv), 32'd0);
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        set_idle();
        burst_mode = 1'b0; oe_n = 1'b0; snooze = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: idle bus after reset
        check_eq("R1 drive after reset", 32'(dq_drv), 32'd0);
        check_eq("R1 data after reset", dq_o, 32'd0);

        // R3 R4 R5 R12: every base position, both orders, six-beat wrapping reads
        for (int ilv = 0; ilv < 2; ilv++) begin
            for (int b = 0; b < 4; b++) begin
                int g;
                g = ilv * 4 + b;
                write_burst(AW'(g * 4 + b), ilv[0], 4, 4'h0, 1'b1, 1'b0,
                            32'hA0000000 + 32'(g) * 32'h00110011);
                read_burst(AW'(g * 4 + b), ilv[0], 6,
                           ilv[0] ? "R4 interleaved R5 wrap R12" : "R3 linear R5 wrap R12");
            end
        end

        // R3 R4: read each group in the order opposite to the one used to write it
        for (int g = 0; g < 8; g++) begin
            bit ilv;
            ilv = (g < 4);
            read_burst(AW'(g * 4 + (3 - g % 4)), ilv, 4,
                       ilv ? "R4 cross-order" : "R3 cross-order");
        end

        // R6: all sixteen lane masks over a known background
        for (int m = 0; m < 16; m++) begin
            write_burst(AW'(32 + m), 1'b0, 1, 4'hF, 1'b0, 1'b1, 32'h5A5A5A5A ^ 32'(m));
            write_burst(AW'(32 + m), 1'b0, 1, ~4'(m), 1'b1, 1'b0, 32'hC3C3C3C3 + 32'(m * 3));
            read_burst(AW'(32 + m), 1'b0, 1, "R6 lane mask");
        end

        // R7: global write alone, then overriding a partial mask
        write_burst(AW'(48), 1'b0, 1, 4'hF, 1'b0, 1'b1, 32'h0BADF00D);
        read_burst(AW'(48), 1'b0, 1, "R7 global write");
        write_burst(AW'(48), 1'b0, 1, 4'b1010, 1'b0, 1'b0, 32'h12345678);
        read_burst(AW'(48), 1'b0, 1, "R7 global over mask");

        // R8: write strobe with no lanes enabled
        write_burst(AW'(48), 1'b0, 1, 4'hF, 1'b1, 1'b0, 32'hFFFFFFFF);
        read_burst(AW'(48), 1'b0, 1, "R8 no lane write");

        // R9: deselect after one beat, then reselect without a start
        ce_n = 1'b0; adsc_n = 1'b0; addr = '0; burst_mode = 1'b0;
        tick();
        ce_n = 1'b1; adsc_n = 1'b1;
        tick();
        ce_n = 1'b0; adsc_n = 1'b1; addr = AW'(5);
        tick();
        check_eq("R2 single beat drive", 32'(dq_drv), 32'd1);
        check_eq("R2 single beat data", dq_o, exp_mem[0]);
        for (int k = 0; k < 3; k++) begin
            tick();
            check_eq("R9 no access after deselect", 32'(dq_drv), 32'd0);
        end
        set_idle();
        tick();
        tick();

        // R10: output enable gates drivers between edges
        ce_n = 1'b0; adsc_n = 1'b0; addr = AW'(5);
        tick();
        set_idle();
        tick();
        tick();
        oe_n = 1'b1;
        #1;
        check_eq("R10 drive with oe_n high", 32'(dq_drv), 32'd0);
        check_eq("R10 data with oe_n high", dq_o, 32'd0);
        oe_n = 1'b0;
        #1;
        check_eq("R10 data restored", dq_o, exp_mem[5]);
        tick();
        tick();

        // R11: snooze cuts drivers of a finished read
        ce_n = 1'b0; adsc_n = 1'b0; addr = AW'(6);
        tick();
        set_idle();
        tick();
        snooze = 1'b1;
        tick();
        check_eq("R11 drive during snooze", 32'(dq_drv), 32'd0);
        snooze = 1'b0;
        #1;
        check_eq("R11 data after snooze", dq_o, exp_mem[6]);
        tick();
        tick();

        // R11: a global write attempted while snoozing is dropped
        write_burst(AW'(50), 1'b0, 1, 4'hF, 1'b0, 1'b1, 32'h76543210);
        snooze = 1'b1;
        ce_n = 1'b0; adsc_n = 1'b0; addr = AW'(50); gw_n = 1'b0; wdata = 32'hDEADBEEF;
        tick();
        adsc_n = 1'b1;
        tick();
        set_idle();
        tick();
        tick();
        check_eq("R11 no drive while snoozing", 32'(dq_drv), 32'd0);
        snooze = 1'b0;
        tick();
        read_burst(AW'(50), 1'b0, 1, "R11 contents retained");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule